// File: doc/BRIEF.md
# Programmable System Clock Prescaler

This block slows down the logic it feeds without touching any clock net. It watches a free-running source clock and raises a one-cycle clock-enable strobe, `tick_en`. Downstream registers advance only on cycles where the strobe is high. Software controls the rate through one 8-bit control word on a simple write port, and can read the word back at any time. The top bit switches division on. The lower seven bits hold a code `d`, and the division factor is `129 - d`. The factor therefore runs from 2 (code 127) down to 129 (code 0).

The code is locked while division is active. It is taken only by the same write that switches division on. A write that keeps the enable set leaves the running code alone. A write that clears the enable drops the code it carries. The rate can be changed at run time by first switching division off and then switching it on again with a new code.

Inside, a two-state machine drives the strobe. In `ST_FULL` the strobe is high on every source cycle. `ST_FULL` moves to `ST_DIV` on an accepted enabling write (transition `GO_DIV`), and at that moment the cycle counter is cleared. In `ST_DIV` the counter steps once per source cycle and wraps at `128 - d`. The strobe is high only on the wrap cycle. `ST_DIV` stays put on every other write, and returns to `ST_FULL` on a write that clears the enable (transition `GO_FULL`).

Top module: `clkdiv_top`

## Requirements
- R1: After reset the control word reads 0x00 and `tick_en` is high on every cycle.
- R2: While the enable bit (bit 7) is 0, `tick_en` is high on every source cycle.
- R3: A write with bit 7 = 1, made while the enable is 0, sets the enable and loads bits 6..0 as code `d`. From the next cycle the read-back shows {1, d}.
- R4: While enabled, `tick_en` pulses once every `129 - d` source cycles. Each pulse is exactly one cycle wide. This holds for d = 0, 1, 64 and 127, which give factors 129, 128, 65 and 2.
- R5: After an accepted enabling write at clock edge k, the first pulse is seen in the cycle after edge k + (129 - d) - 1. That is the (129 - d)-th cycle after the write.
- R6: A write with bit 7 = 1 made while already enabled is ignored. The read-back code does not change, and the pulse cadence continues without restarting.
- R7: A write with bit 7 = 0 clears the enable and discards the code it carries. The read-back code keeps its previous value.
- R8: After a disabling write at edge m, `tick_en` is high from the cycle following edge m onward.
- R9: Enabling again after a disable loads the newly supplied code, and the count restarts from zero.
- R10: A cycle with `wr_en` low leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write value: bit 7 is the enable, bits 6..0 are the code |
| rd_data | output | 8 | Current control word |
| tick_en | output | 1 | Clock-enable strobe at the divided rate |

## Verification
A wrong state or counter value shows at `tick_en` within one division period. A counter that fails to restart moves the first pulse away from its expected cycle. A wrong wrap value shifts every later pulse. The state machine and the control register both hold the enable, so a disagreement between them shows at once as a strobe that is high while the read-back says divided, or a strobe that is low while it says undivided. Code-lock faults show on `rd_data` in the cycle after the offending write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic [0:0] {
        ST_FULL = 1'b0,
        ST_DIV  = 1'b1
    } div_state_e;

    typedef struct packed {
        logic       en;
        logic [6:0] code;
    } ctrl_word_t;
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W:0]   wr_data,
    output logic              en_q,
    output logic [CODE_W-1:0] code_q,
    output logic              load_evt,
    output logic              stop_evt
);
    localparam int EN_BIT = CODE_W;

    logic wr_set;

    // A write that sets the enable is accepted only from the disabled state.
    assign wr_set   = wr_en && wr_data[EN_BIT];
    assign load_evt = wr_set && !en_q;
    assign stop_evt = wr_en && !wr_data[EN_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            code_q <= '0;
        end else if (load_evt) begin
            en_q   <= 1'b1;
            code_q <= wr_data[CODE_W-1:0];
        end else if (stop_evt) begin
            en_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/clkdiv_limit.sv
module clkdiv_limit #(
    parameter int CODE_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  last
);
    localparam int TOP = 1 << CODE_W;

    // The factor is TOP + 1 - code, so the wrap value is TOP - code.
    always_comb begin
        last = CNT_W'(TOP) - CNT_W'(code);
    end
endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_evt,
    input  logic             stop_evt,
    input  logic [CNT_W-1:0] last,
    output logic             tick_en
);
    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_wrap;

    assign at_wrap = (cnt_q == last);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FULL: begin
                cnt_d = '0;
                if (load_evt) begin
                    state_d = ST_DIV;
                end
            end
            ST_DIV: begin
                if (stop_evt) begin
                    state_d = ST_FULL;
                    cnt_d   = '0;
                end else begin
                    cnt_d = at_wrap ? '0 : cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_FULL;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FULL: tick_en = 1'b1;
            ST_DIV:  tick_en = at_wrap;
            default: tick_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
    parameter int CODE_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CODE_W:0] wr_data,
    output logic [CODE_W:0] rd_data,
    output logic            tick_en
);
    localparam int MAX_FACTOR = (1 << CODE_W) + 1;
    localparam int CNT_W      = $clog2(MAX_FACTOR);

    logic              en_q;
    logic [CODE_W-1:0] code_q;
    logic              load_evt;
    logic              stop_evt;
    logic [CNT_W-1:0]  last;

    clkdiv_ctrl_reg #(.CODE_W(CODE_W)) reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .en_q     (en_q),
        .code_q   (code_q),
        .load_evt (load_evt),
        .stop_evt (stop_evt)
    );

    clkdiv_limit #(.CODE_W(CODE_W), .CNT_W(CNT_W)) lim_i (
        .code (code_q),
        .last (last)
    );

    clkdiv_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_evt (load_evt),
        .stop_evt (stop_evt),
        .last     (last),
        .tick_en  (tick_en)
    );

    assign rd_data = {en_q, code_q};
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
    parameter int CODE_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [CODE_W:0] wr_data,
    input logic [CODE_W:0] rd_data,
    input logic            tick_en
);
    a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[CODE_W] |-> tick_en);

    a_r4_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[CODE_W] && tick_en) |=> (!rd_data[CODE_W] || !tick_en));

    a_r5_no_early_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[CODE_W]) |-> !tick_en);

    a_r6_code_locked: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CODE_W] |=> (!rd_data[CODE_W] || $stable(rd_data[CODE_W-1:0])));

    a_r7_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[CODE_W]) |=> (!rd_data[CODE_W] && $stable(rd_data[CODE_W-1:0])));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

bind clkdiv_top clkdiv_chk #(.CODE_W(CODE_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick_en (tick_en)
);

// File: tb/clkdiv_top_tb_top.sv
module clkdiv_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick_en;

    typedef struct {
        logic       tick;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // independent model state
    bit         m_en = 1'b0;
    logic [6:0] m_code = 7'd0;
    int         m_since = 0;

    always #4 clk = ~clk;

    clkdiv_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .tick_en (tick_en)
    );

    task automatic check(input logic tick_a, input logic tick_e,
                         input logic [7:0] rd_a, input logic [7:0] rd_e,
                         input string tag);
        n_cmp++;
        if (tick_a !== tick_e || rd_a !== rd_e) begin
            n_bad++;
            $display("FAIL %s: tick_en=%0b rd_data=%02h expected tick_en=%0b rd_data=%02h",
                     tag, tick_a, rd_a, tick_e, rd_e);
        end
    endtask

    // driver: one call per source cycle, pushes what the next edge must produce
    task automatic drive(input logic we, input logic [7:0] d, input string tag);
        exp_t e;
        int   f;
        @(negedge clk);
        wr_en   = we;
        wr_data = d;
        if (we) begin
            if (d[7]) begin
                if (!m_en) begin
                    m_en    = 1'b1;
                    m_code  = d[6:0];
                    m_since = 0;
                end
            end else begin
                m_en = 1'b0;
            end
        end
        if (m_en) m_since++;
        f = 129 - int'(m_code);
        e.tick = !m_en || ((m_since % f) == 0);
        e.rd   = {m_en, m_code};
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, 8'h00, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(tick_en, e.tick, rd_data, e.rd, e.tag);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #21;
        check(tick_en, 1'b1, rd_data, 8'h00, "R1 in reset");
        #20;
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(tick_en, 1'b1, rd_data, 8'h00, "R1 after reset");

        idle(6, "R2 R10 disabled idle");
        drive(1'b1, 8'h55, "R7 disabling write drops code");
        idle(4, "R2 R7 still full rate");

        drive(1'b1, 8'h80, "R3 R5 enable d=0");
        idle(200, "R4 R5 d=0 factor 129");
        drive(1'b1, 8'hC0, "R6 write while enabled ignored");
        idle(200, "R4 R6 cadence kept");
        drive(1'b1, 8'h11, "R7 R8 disable");
        idle(5, "R8 full rate after disable");

        drive(1'b1, 8'h81, "R9 R3 enable d=1");
        idle(3 * 128, "R4 R5 d=1 factor 128");
        drive(1'b1, 8'h00, "R8 disable");
        drive(1'b1, 8'hC0, "R9 enable d=64");
        idle(3 * 65, "R4 R5 d=64 factor 65");
        drive(1'b1, 8'h7F, "R7 disable keeps code 64");
        idle(3, "R8 R2 full rate");
        drive(1'b1, 8'hFF, "R9 enable d=127");
        idle(12, "R4 d=127 factor 2");
        drive(1'b1, 8'h80, "R6 ignored at factor 2");
        idle(6, "R4 R6 factor 2 kept");
        drive(1'b1, 8'h00, "R8 final disable");
        idle(4, "R2 R10 final idle");

        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL queue: %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule